// File: doc/BRIEF.md
# Pointer-Indexed Two-Wire Register Slave

This block is a target on a two-wire serial bus (I2C) that exposes four 16-bit registers to a bus master. A pointer register selects the register. Slot 0 is a read-only sample value supplied from the register side. Slot 1 is a configuration word. Slots 2 and 3 are a low and a high limit. The block samples the bus clock and data lines with the system clock and cleans them up. It then detects START, repeated START and STOP, acknowledges bytes and pulls data low through an open-drain enable. Words travel MSB byte first.

A write transaction carries the pointer byte first and then data bytes for the selected register. A read transaction returns the selected register and leaves the pointer unchanged, so repeated reads need no pointer write. The device address is formed from two four-level strap codes. The general-call address is acknowledged in both directions. A high-speed master code is noted and refused. If the clock line is held low for too long, the link is dropped. A one-cycle read strobe tells the neighbouring alarm logic that a read took place.

Top module: `ptr_i2c_regslave`

## Requirements
- R1: The block answers a 7-bit address `{3'b100, hi, lo}`. Strap codes are 0=ground, 1=supply, 2=data line, 3=clock line. `hi` is 2'b01 when the upper strap code is 3 and 2'b10 for any other code. `lo` equals the lower strap code. Any other non-zero address is not acknowledged.
- R2: In a write transaction the byte after the address loads the pointer. The next two bytes are the MSB and LSB of the selected register, and the register changes when the LSB arrives. The configuration word keeps only the bits set in `CFG_WMASK` (default 16'h9FC0). On readback, the bits outside that mask come from `cfg_ro`.
- R3: A read transaction returns the MSB and then the LSB of the register selected by the last pointer write. The pointer is kept, so back-to-back reads return the same register.
- R4: Only pointer bits 1:0 select a register. Bits 7:2 of the pointer byte have no effect.
- R5: A data write with pointer 0 changes no register. Reading slot 0 always returns `temp_val`.
- R6: After reset the configuration is 16'h0080, the low limit 16'h2580 and the high limit 16'h2800. Limit bits 3:0 always hold zero.
- R7: Address 0x00 with the write bit set is acknowledged, and so is the one byte after it, whose value is dropped. Any further byte in that transaction is not acknowledged.
- R8: Address 0x00 with the read bit set is acknowledged and returns the register selected by the pointer.
- R9: A first byte of the form 8'b00001xxx is not acknowledged and sets `hs_active`. `hs_active` stays high through repeated STARTs and clears at the next STOP.
- R10: If the clock line stays low for CLK_KHZ*TOUT_MS system cycles during a transaction, the data line is released. The block then ignores the bus until a new START.
- R11: A master NACK after a transmitted byte releases the data line and ends the transfer. A read of the MSB byte alone followed by STOP is legal.
- R12: `rd_strobe` pulses for exactly one cycle for each acknowledged read address.
- R13: The data-line drive changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_a1 | input | 2 | Upper address strap code (0 gnd, 1 supply, 2 data, 3 clock) |
| strap_a0 | input | 2 | Lower address strap code (same encoding) |
| temp_val | input | 16 | Sample value returned from slot 0 |
| cfg_ro | input | 16 | Read-only configuration bits merged on readback |
| cfg_q | output | 16 | Stored writable configuration bits |
| lo_lim_q | output | 16 | Low limit register |
| hi_lim_q | output | 16 | High limit register |
| rd_strobe | output | 1 | One-cycle pulse per acknowledged read address |
| hs_active | output | 1 | High-speed master code seen since the last STOP |

## Verification
A wrong bit counter or a wrong byte index in the link shows up at the data line within one byte time. It appears as a missing or extra acknowledge, or as a shifted MSB/LSB in a readback, and the scoreboard pops exactly these. A pointer or write-enable fault shows up at the next readback or on the limit and configuration outputs right after the LSB acknowledge. The bench therefore reads back after every write and checks the register outputs after ignored writes. A timeout or STOP fault is exposed because the bench probes the acknowledge of the next foreign or orphan byte.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [2:0] {
    L_IDLE,
    L_RX,
    L_ACK,
    L_TX,
    L_MACK
  } link_st_t;

  typedef enum logic [1:0] {
    K_WR,
    K_GC,
    K_RD
  } xfer_t;

  localparam logic [1:0] STRAP_GND  = 2'd0;
  localparam logic [1:0] STRAP_SUP  = 2'd1;
  localparam logic [1:0] STRAP_DATA = 2'd2;
  localparam logic [1:0] STRAP_CLK  = 2'd3;

  // Device address from strap codes: upper strap on the clock line moves the
  // window down by four.
  function automatic logic [6:0] own_addr(input logic [1:0] a1, input logic [1:0] a0);
    return {3'b100, (a1 == STRAP_CLK) ? 2'b01 : 2'b10, a0};
  endfunction

endpackage

// File: rtl/i2c_rs_infilt.sv
module i2c_rs_infilt #(
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int CW = $clog2(TAPS + 1);

  logic [1:0]      sync_q;
  logic [TAPS-1:0] hist_q;
  logic            out_q;
  logic            out_d;
  logic [CW-1:0]   ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + CW'(hist_q[i]);
    end
    out_d = (ones > CW'(TAPS / 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      hist_q <= {hist_q[TAPS-2:0], sync_q[1]};
      out_q  <= out_d;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
  parameter int              DW        = 16,
  parameter logic [DW-1:0]   CFG_WMASK = 16'h9FC0,
  parameter logic [DW-1:0]   CFG_RST   = 16'h0080,
  parameter logic [DW-1:0]   LO_RST    = 16'h2580,
  parameter logic [DW-1:0]   HI_RST    = 16'h2800,
  parameter int              LIM_ZERO  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic [1:0]    ptr_wd,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wd,
  input  logic [DW-1:0] temp_val,
  input  logic [DW-1:0] cfg_ro,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q
);

  localparam logic [DW-1:0] LIM_MASK = {{(DW-LIM_ZERO){1'b1}}, {LIM_ZERO{1'b0}}};

  logic [1:0]    ptr_q;
  logic [DW-1:0] cfg_r;
  logic [DW-1:0] lim_w [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= 2'd0;
    else if (ptr_we) ptr_q <= ptr_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cfg_r <= CFG_RST & CFG_WMASK;
    else if (reg_we && ptr_q == 2'd1)   cfg_r <= reg_wd & CFG_WMASK;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lim
    localparam logic [DW-1:0] RST_V = (g == 0) ? LO_RST : HI_RST;
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= RST_V & LIM_MASK;
      else if (reg_we && ptr_q == 2'(g + 2)) q <= reg_wd & LIM_MASK;
    end
    assign lim_w[g] = q;
  end

  always_comb begin
    case (ptr_q)
      2'd0:    rd_word = temp_val;
      2'd1:    rd_word = (cfg_r & CFG_WMASK) | (cfg_ro & ~CFG_WMASK);
      2'd2:    rd_word = lim_w[0];
      default: rd_word = lim_w[1];
    endcase
  end

  assign cfg_q = cfg_r;
  assign lo_q  = lim_w[0];
  assign hi_q  = lim_w[1];

  // R4: pointer moves only on a pointer write
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we |=> $stable(ptr_q));

  // R5: data written to slot 0 leaves every stored register untouched
  a_r5_slot0_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ptr_q == 2'd0) |=> ($stable(cfg_r) && $stable(lim_w[0]) && $stable(lim_w[1])));

endmodule

// File: rtl/i2c_rs_link.sv
module i2c_rs_link
  import i2c_rs_pkg::*;
#(
  parameter int DW       = 16,
  parameter int TOUT_CYC = 3750000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [6:0]    my_addr,
  input  logic [DW-1:0] rd_word,
  output logic          ptr_we,
  output logic [1:0]    ptr_wd,
  output logic          reg_we,
  output logic [DW-1:0] reg_wd,
  output logic          rd_strobe,
  output logic          sda_oe,
  output logic          hs_active
);

  localparam int TW = $clog2(TOUT_CYC + 1);
  localparam int BW = DW / 2;

  link_st_t       st_q, st_d;
  xfer_t          kind_q, kind_d;
  logic [3:0]     cnt_q, cnt_d;
  logic [6:0]     sh_q, sh_d;
  logic           oe_q, oe_d;
  logic           ackph_q, ackph_d;
  logic           nxt_tx_q, nxt_tx_d;
  logic [1:0]     bidx_q, bidx_d;
  logic           first_q, first_d;
  logic [BW-1:0]  msb_q, msb_d;
  logic [DW-1:0]  txw_q, txw_d;
  logic           txsel_q, txsel_d;
  logic           hs_q, hs_d;
  logic           rds_q, rds_d;
  logic [TW-1:0]  tcnt_q, tcnt_d;
  logic           scl_p, sda_p;

  logic          start_ev, stop_ev, rise_ev, fall_ev, tout;
  logic [7:0]    byte_in;
  logic [BW-1:0] cur_byte;
  logic [2:0]    bit_ix;

  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
  assign rise_ev  = scl_f & ~scl_p;
  assign fall_ev  = ~scl_f & scl_p;
  assign byte_in  = {sh_q, sda_f};
  assign cur_byte = txsel_q ? txw_q[BW-1:0] : txw_q[DW-1:BW];
  assign bit_ix   = 3'd7 - cnt_q[2:0];
  assign tout     = (st_q != L_IDLE) && !scl_f && (tcnt_q == TW'(TOUT_CYC - 1));

  assign ptr_wd = byte_in[1:0];
  assign reg_wd = {msb_q, byte_in};

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    ackph_d  = ackph_q;
    nxt_tx_d = nxt_tx_q;
    bidx_d   = bidx_q;
    first_d  = first_q;
    msb_d    = msb_q;
    txw_d    = txw_q;
    txsel_d  = txsel_q;
    hs_d     = hs_q;
    rds_d    = 1'b0;
    ptr_we   = 1'b0;
    reg_we   = 1'b0;
    tcnt_d   = (st_q == L_IDLE || scl_f) ? '0 : tcnt_q + 1'b1;

    if (start_ev) begin
      st_d    = L_RX;
      cnt_d   = 4'd0;
      first_d = 1'b1;
      oe_d    = 1'b0;
      ackph_d = 1'b0;
    end else if (stop_ev) begin
      st_d = L_IDLE;
      oe_d = 1'b0;
      hs_d = 1'b0;
    end else if (tout) begin
      st_d = L_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        L_RX: begin
          if (rise_ev) begin
            sh_d  = byte_in[6:0];
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              st_d     = L_ACK;
              ackph_d  = 1'b0;
              nxt_tx_d = 1'b0;
              first_d  = 1'b0;
              if (first_q) begin
                if (byte_in[7:3] == 5'b00001) begin
                  hs_d = 1'b1;
                  st_d = L_IDLE;
                end else if (byte_in[7:1] == my_addr || byte_in[7:1] == 7'd0) begin
                  if (byte_in[0]) begin
                    kind_d   = K_RD;
                    nxt_tx_d = 1'b1;
                    txw_d    = rd_word;
                    txsel_d  = 1'b0;
                    rds_d    = 1'b1;
                  end else begin
                    kind_d = (byte_in[7:1] == 7'd0) ? K_GC : K_WR;
                    bidx_d = 2'd0;
                  end
                end else begin
                  st_d = L_IDLE;
                end
              end else if (kind_q == K_GC) begin
                if (bidx_q == 2'd0) bidx_d = 2'd1;
                else                st_d   = L_IDLE;
              end else begin
                case (bidx_q)
                  2'd0: begin ptr_we = 1'b1; bidx_d = 2'd1; end
                  2'd1: begin msb_d = byte_in; bidx_d = 2'd2; end
                  default: begin reg_we = 1'b1; bidx_d = 2'd1; end
                endcase
              end
            end
          end
        end
        L_ACK: begin
          if (fall_ev) begin
            if (!ackph_q) begin
              oe_d    = 1'b1;
              ackph_d = 1'b1;
            end else begin
              ackph_d = 1'b0;
              if (nxt_tx_q) begin
                st_d  = L_TX;
                oe_d  = ~cur_byte[7];
                cnt_d = 4'd1;
              end else begin
                st_d  = L_RX;
                oe_d  = 1'b0;
                cnt_d = 4'd0;
              end
            end
          end
        end
        L_TX: begin
          if (fall_ev) begin
            if (cnt_q == 4'd8) begin
              oe_d    = 1'b0;
              st_d    = L_MACK;
              ackph_d = 1'b0;
            end else begin
              oe_d  = ~cur_byte[bit_ix];
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        L_MACK: begin
          if (rise_ev && !ackph_q) begin
            if (sda_f) begin
              st_d = L_IDLE;
            end else begin
              ackph_d = 1'b1;
              txsel_d = ~txsel_q;
            end
          end else if (fall_ev && ackph_q) begin
            ackph_d = 1'b0;
            st_d    = L_TX;
            oe_d    = ~cur_byte[7];
            cnt_d   = 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= L_IDLE;
      kind_q   <= K_WR;
      cnt_q    <= 4'd0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      ackph_q  <= 1'b0;
      nxt_tx_q <= 1'b0;
      bidx_q   <= 2'd0;
      first_q  <= 1'b0;
      msb_q    <= '0;
      txw_q    <= '0;
      txsel_q  <= 1'b0;
      hs_q     <= 1'b0;
      rds_q    <= 1'b0;
      tcnt_q   <= '0;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      st_q     <= st_d;
      kind_q   <= kind_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      oe_q     <= oe_d;
      ackph_q  <= ackph_d;
      nxt_tx_q <= nxt_tx_d;
      bidx_q   <= bidx_d;
      first_q  <= first_d;
      msb_q    <= msb_d;
      txw_q    <= txw_d;
      txsel_q  <= txsel_d;
      hs_q     <= hs_d;
      rds_q    <= rds_d;
      tcnt_q   <= tcnt_d;
      scl_p    <= scl_f;
      sda_p    <= sda_f;
    end
  end

  assign sda_oe    = oe_q;
  assign hs_active = hs_q;
  assign rd_strobe = rds_q;

  // R13: drive on the data line moves only after the clock was seen low
  a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !$past(scl_f));

  // R10: an expired low-clock window frees the line and idles the link
  a_r10_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    tout |=> (!oe_q && st_q == L_IDLE));

  // R9: high-speed flag falls at STOP
  a_r9_stop_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !hs_q);

  // R11: master NACK after a sent byte ends the transfer
  a_r11_nack_ends_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_MACK && rise_ev && !ackph_q && sda_f) |=> (st_q == L_IDLE && !oe_q));

  // R12: read strobe is a single-cycle pulse
  a_r12_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rds_q |=> !rds_q);

endmodule

// File: rtl/ptr_i2c_regslave.sv
module ptr_i2c_regslave
  import i2c_rs_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            CLK_KHZ   = 125000,
  parameter int            TOUT_MS   = 30,
  parameter int            FILT_TAPS = 3,
  parameter logic [15:0]   CFG_WMASK = 16'h9FC0,
  parameter logic [15:0]   CFG_RST   = 16'h0080,
  parameter logic [15:0]   LO_RST    = 16'h2580,
  parameter logic [15:0]   HI_RST    = 16'h2800,
  parameter int            LIM_ZERO  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    strap_a1,
  input  logic [1:0]    strap_a0,
  input  logic [DW-1:0] temp_val,
  input  logic [DW-1:0] cfg_ro,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] lo_lim_q,
  output logic [DW-1:0] hi_lim_q,
  output logic          rd_strobe,
  output logic          hs_active
);

  localparam int TOUT_CYC = CLK_KHZ * TOUT_MS;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [1:0]    line_raw;
  logic [1:0]    line_flt;
  logic          ptr_we, reg_we;
  logic [1:0]    ptr_wd;
  logic [DW-1:0] reg_wd, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    i2c_rs_infilt #(.TAPS(FILT_TAPS)) u_flt (
      .clk  (clk),
      .rst_n(rst_int_n),
      .din  (line_raw[g]),
      .dout (line_flt[g])
    );
  end

  i2c_rs_link #(.DW(DW), .TOUT_CYC(TOUT_CYC)) u_link (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_f    (line_flt[0]),
    .sda_f    (line_flt[1]),
    .my_addr  (own_addr(strap_a1, strap_a0)),
    .rd_word  (rd_word),
    .ptr_we   (ptr_we),
    .ptr_wd   (ptr_wd),
    .reg_we   (reg_we),
    .reg_wd   (reg_wd),
    .rd_strobe(rd_strobe),
    .sda_oe   (sda_oe),
    .hs_active(hs_active)
  );

  i2c_rs_regs #(
    .DW(DW), .CFG_WMASK(CFG_WMASK), .CFG_RST(CFG_RST),
    .LO_RST(LO_RST), .HI_RST(HI_RST), .LIM_ZERO(LIM_ZERO)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ptr_we  (ptr_we),
    .ptr_wd  (ptr_wd),
    .reg_we  (reg_we),
    .reg_wd  (reg_wd),
    .temp_val(temp_val),
    .cfg_ro  (cfg_ro),
    .rd_word (rd_word),
    .cfg_q   (cfg_q),
    .lo_q    (lo_lim_q),
    .hi_q    (hi_lim_q)
  );

endmodule

// File: tb/sim_ptr_i2c_regslave.sv
`timescale 1ns/1ps
module sim_ptr_i2c_regslave;

  localparam int Q        = 12;
  localparam int CLK_KHZ  = 100;
  localparam int TOUT_MS  = 30;
  localparam int TOUT_CYC = CLK_KHZ * TOUT_MS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_scl, m_sda;
  logic        sda_oe;
  logic [1:0]  strap_a1, strap_a0;
  logic [15:0] temp_val, cfg_ro;
  logic [15:0] cfg_q, lo_lim_q, hi_lim_q;
  logic        rd_strobe, hs_active;
  logic        sda_bus;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  ptr_i2c_regslave #(.CLK_KHZ(CLK_KHZ), .TOUT_MS(TOUT_MS)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_a1(strap_a1), .strap_a0(strap_a0), .temp_val(temp_val), .cfg_ro(cfg_ro),
    .cfg_q(cfg_q), .lo_lim_q(lo_lim_q), .hi_lim_q(hi_lim_q),
    .rd_strobe(rd_strobe), .hs_active(hs_active)
  );

  int nvec = 0;
  int nfail = 0;
  int rd_seen = 0;
  int exp_rd = 0;
  int edge_bad = 0;
  bit done = 0;

  string       q_req[$];
  logic [15:0] q_val[$];

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_item(input string req, input logic [15:0] v);
    q_req.push_back(req);
    q_val.push_back(v);
  endtask

  // monitor side: pop and compare against what the bus produced
  task automatic observe(input logic [15:0] v);
    string r;
    logic [15:0] e;
    if (q_val.size() == 0) begin
      nvec++; nfail++;
      $display("FAIL scoreboard-empty actual=%h expected=none", v);
    end else begin
      r = q_req.pop_front();
      e = q_val.pop_front();
      chk(r, v, e);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b;    wt(Q);
    m_scl = 1'b1; wt(2*Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    b = sda_bus;  wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(~mack);
  endtask

  task automatic w_byte(input string req, input logic [7:0] b, input logic exp_ack);
    logic a;
    expect_item(req, {15'd0, exp_ack});
    wr_byte(b, a);
    observe({15'd0, a});
  endtask

  task automatic r_byte(input string req, input logic [7:0] exp_b, input logic mack);
    logic [7:0] b;
    expect_item(req, {8'd0, exp_b});
    rd_byte(b, mack);
    observe({8'd0, b});
  endtask

  task automatic write_reg(input string req, input logic [6:0] a, input logic [7:0] p, input logic [15:0] w);
    bus_start();
    w_byte(req, {a, 1'b0}, 1'b1);
    w_byte(req, p, 1'b1);
    w_byte(req, w[15:8], 1'b1);
    w_byte(req, w[7:0], 1'b1);
    bus_stop();
  endtask

  task automatic set_ptr(input string req, input logic [6:0] a, input logic [7:0] p);
    bus_start();
    w_byte(req, {a, 1'b0}, 1'b1);
    w_byte(req, p, 1'b1);
    bus_stop();
  endtask

  task automatic read_reg(input string req, input logic [6:0] a, input logic [15:0] exp_w);
    bus_start();
    w_byte(req, {a, 1'b1}, 1'b1);
    exp_rd++;
    r_byte(req, exp_w[15:8], 1'b1);
    r_byte(req, exp_w[7:0], 1'b0);
    bus_stop();
  endtask

  always @(posedge clk) if (rst_n && rd_strobe) rd_seen++;

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (sda_oe !== prev_oe && m_scl === 1'b1) edge_bad++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  localparam logic [6:0] ME = 7'h4A;

  initial begin
    logic a;
    logic [7:0] b;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    strap_a1 = 2'd0; strap_a0 = 2'd2;
    temp_val = 16'h1234; cfg_ro = 16'h4020;
    wt(5);
    rst_n = 1'b1;
    wt(12);

    // R6 reset values
    chk("R6 cfg reset", cfg_q, 16'h0080);
    chk("R6 lo reset", lo_lim_q, 16'h2580);
    chk("R6 hi reset", hi_lim_q, 16'h2800);
    chk("R6 sda idle", {15'd0, sda_oe}, 16'd0);
    chk("R9 hs idle", {15'd0, hs_active}, 16'd0);

    // R1 foreign address ignored
    bus_start(); w_byte("R1 foreign 0x48", {7'h48, 1'b0}, 1'b0); bus_stop();

    // R3 read after reset returns slot 0
    read_reg("R3 slot0 read", ME, 16'h1234);

    // R2 / R6 limit write with nibble clear
    write_reg("R2 write lo", ME, 8'h02, 16'hABCD);
    chk("R6 lo nibble cleared", lo_lim_q, 16'hABC0);
    read_reg("R3 reread lo a", ME, 16'hABC0);
    read_reg("R3 reread lo b", ME, 16'hABC0);

    // R4 pointer upper bits ignored, R2 config mask
    write_reg("R4 ptr 0x05", ME, 8'h05, 16'hFFFF);
    chk("R2 cfg stored mask", cfg_q, 16'h9FC0);
    read_reg("R2 cfg readback merge", ME, 16'hDFE0);

    // R5 slot 0 write has no effect
    temp_val = 16'h0C80;
    write_reg("R5 slot0 write", ME, 8'hFC, 16'h5555);
    chk("R5 cfg unchanged", cfg_q, 16'h9FC0);
    chk("R5 lo unchanged", lo_lim_q, 16'hABC0);
    chk("R5 hi unchanged", hi_lim_q, 16'h2800);
    read_reg("R5 slot0 still input", ME, 16'h0C80);

    // R7 general call write
    set_ptr("R7 ptr hi", ME, 8'h03);
    bus_start();
    w_byte("R7 gc addr", 8'h00, 1'b1);
    w_byte("R7 gc byte2", 8'h02, 1'b1);
    w_byte("R7 gc byte3 nack", 8'h77, 1'b0);
    bus_stop();
    chk("R7 lo untouched", lo_lim_q, 16'hABC0);
    chk("R7 hi untouched", hi_lim_q, 16'h2800);

    // R8 general call read uses pointer
    read_reg("R8 gc read", 7'h00, 16'h2800);

    // R9 high-speed master code
    bus_start();
    w_byte("R9 hs code nack", 8'h0A, 1'b0);
    chk("R9 hs set", {15'd0, hs_active}, 16'd1);
    bus_start();
    w_byte("R9 addr in hs", {ME, 1'b1}, 1'b1);
    exp_rd++;
    r_byte("R11 msb only", 8'h28, 1'b0);
    chk("R9 hs kept", {15'd0, hs_active}, 16'd1);
    chk("R11 released after nack", {15'd0, sda_oe}, 16'd0);
    bus_stop();
    chk("R9 hs cleared", {15'd0, hs_active}, 16'd0);

    // R10 timeout during the address acknowledge
    bus_start();
    for (int i = 7; i >= 0; i--) bit_out(((ME << 1) >> i) & 1);
    m_sda = 1'b1;
    wt(20);
    chk("R10 ack held", {15'd0, sda_oe}, 16'd1);
    wt(TOUT_CYC + 40);
    chk("R10 released", {15'd0, sda_oe}, 16'd0);
    w_byte("R10 idle until start", {ME, 1'b0}, 1'b0);
    bus_stop();
    read_reg("R10 recovers", ME, 16'h2800);

    // R1 other strap settings
    strap_a1 = 2'd3; strap_a0 = 2'd2;
    wt(4);
    bus_start(); w_byte("R1 old addr nack", {ME, 1'b0}, 1'b0); bus_stop();
    read_reg("R1 addr 0x46", 7'h46, 16'h2800);
    strap_a1 = 2'd1; strap_a0 = 2'd1;
    wt(4);
    bus_start(); w_byte("R1 addr 0x49", {7'h49, 1'b0}, 1'b1); bus_stop();

    wt(20);
    chk("R12 strobe count", 16'(rd_seen), 16'(exp_rd));
    chk("R13 drive edges", 16'(edge_bad), 16'd0);
    chk("R3 scoreboard drained", 16'(q_val.size()), 16'd0);
    summary();
  end

endmodule